// File: doc/BRIEF.md
# Fuse Line Programming Sequencer

This block drives the one-time programming of a bank of fuse lines. Each line stores 65 bits: a 32-bit low word (bits 31:0), a 32-bit high word (bits 63:32) and a lock bit (bit 64). A client hands over one request through a valid/ready handshake. A request is either a read of one line or a program operation. A program operation carries a line number, a 64-bit value, a mask for each 32-bit half and a lock flag. The block answers every request with a one-cycle `done` pulse and a status code.

A program operation is checked first. The block then raises the program-enable output and reads the line. If the line is already locked, it gives up. Otherwise it ORs the masked new bits into the old contents, so fuses are only ever set and never cleared. It writes the result back as three word strobes in a fixed order, spaced by timers counted in clock cycles. The fuse array sits outside the block and is reached through a simple read/write port. A read has a one-cycle latency: data is valid in the cycle after the read strobe.

Top module: `fuse_prog_seq`

## Requirements
- R1: A request whose line number is 64 or higher finishes with status NODEV (2). No array read or write is made. This check takes precedence over all other checks.
- R2: A read request returns the low word, the high word and the lock bit of the addressed line on `rd_lo`, `rd_hi` and `rd_lock`, with status OK (0). `prog_en` stays low throughout.
- R3: A program request to a line whose stored bit 64 is 1 finishes with status PERM (1), and no write strobe is issued.
- R4: After a successful program operation, the line holds: low = old_low | (new[31:0] & mask_lo), high = old_high | (new[63:32] & mask_hi), lock = old_lock | lock_flag.
- R5: The write strobes go out in the order low (`fa_wsel`=0), high (1), lock (2). Consecutive strobes are exactly CYC_PER_MS cycles apart. `done` comes exactly 5*CYC_PER_MS cycles after the lock strobe.
- R6: For a program operation that passes the request checks, `prog_en` is high during the line read and during every write strobe. It is low again in the cycle `done` is high, on both the OK path and the PERM path.
- R7: A program request with the lock flag clear finishes with status INVAL (3) and writes nothing. The lock word always writes data value 1.
- R8: A program request with any of data bits 63:57 set finishes with status INVAL (3) and writes nothing. Bit 56 alone is accepted.
- R9: A program request whose 64-bit data is zero while either mask is nonzero finishes with status OK. It writes nothing and never raises `prog_en`, even on a locked line.
- R10: `req_ready` is high only while the block is idle. `done` is a single-cycle pulse. After reset, `req_ready`=1 and `done`, `prog_en` and `fa_wr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = program operation, 0 = read |
| req_line | input | LINE_W | Line number |
| req_data | input | 64 | New line data |
| req_mask_lo | input | 32 | Mask for data bits 31:0 |
| req_mask_hi | input | 32 | Mask for data bits 63:32 |
| req_lock | input | 1 | Lock flag for the line |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 OK, 1 PERM, 2 NODEV, 3 INVAL |
| rd_lo | output | 32 | Read result, bits 31:0 |
| rd_hi | output | 32 | Read result, bits 63:32 |
| rd_lock | output | 1 | Read result, bit 64 |
| prog_en | output | 1 | Global program enable |
| fa_addr | output | ADDR_W | Array line address |
| fa_rd | output | 1 | Array read strobe |
| fa_rdata | input | 65 | Array read data, valid the cycle after `fa_rd` |
| fa_wr | output | 1 | Array write strobe |
| fa_wsel | output | 2 | Word select: 0 low, 1 high, 2 lock |
| fa_wdata | output | 32 | Array write data |

## Verification
Two things can land in the same cycle. The first is the `done` pulse of one request and the acceptance of the next: `req_ready` rises in the very cycle `done` is high. The bench drives its next request in that cycle, so back-to-back requests are exercised all through the random run, and each result is judged against its own expected status and line contents. The second is a set of rejection conditions arriving together in one request: an out-of-range line with a missing lock flag and set ECC bits, or a zero-data request on a locked line. These are provoked directly. They are judged on which status wins (NODEV, then INVAL, then the zero-data completion ahead of PERM).

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int WORD_W  = 32;
  localparam int DATA_W  = 64;
  localparam int ECC_LSB = 57;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_PERM  = 2'd1,
    ST_NODEV = 2'd2,
    ST_INVAL = 2'd3
  } fps_status_e;

  typedef enum logic [1:0] {
    WSEL_LO   = 2'd0,
    WSEL_HI   = 2'd1,
    WSEL_LOCK = 2'd2
  } fps_wsel_e;
endpackage

// File: rtl/fps_check.sv
// Request screening: line range, then lock flag and ECC bits, then zero-data skip.
module fps_check
  import fps_pkg::*;
#(
  parameter int LINE_W    = 8,
  parameter int NUM_LINES = 64
) (
  input  logic              is_write,
  input  logic [LINE_W-1:0] line,
  input  logic [DATA_W-1:0] data,
  input  logic [WORD_W-1:0] mask_lo,
  input  logic [WORD_W-1:0] mask_hi,
  input  logic              lock,
  output logic              reject,
  output fps_status_e       code,
  output logic              skip
);
  localparam logic [LINE_W:0] LINE_LIM = (LINE_W+1)'(NUM_LINES);

  always_comb begin
    reject = 1'b0;
    code   = ST_OK;
    skip   = 1'b0;
    if ({1'b0, line} >= LINE_LIM) begin
      reject = 1'b1;
      code   = ST_NODEV;
    end else if (is_write) begin
      if (!lock || (|data[DATA_W-1:ECC_LSB])) begin
        reject = 1'b1;
        code   = ST_INVAL;
      end else if ((data == '0) && ((|mask_lo) || (|mask_hi))) begin
        skip = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fps_merge.sv
// OR-only merge of masked new bits into the stored line.
module fps_merge
  import fps_pkg::*;
(
  input  logic [WORD_W-1:0] old_lo,
  input  logic [WORD_W-1:0] old_hi,
  input  logic              old_lock,
  input  logic [DATA_W-1:0] new_data,
  input  logic [WORD_W-1:0] mask_lo,
  input  logic [WORD_W-1:0] mask_hi,
  input  logic              new_lock,
  output logic [WORD_W-1:0] mg_lo,
  output logic [WORD_W-1:0] mg_hi,
  output logic              mg_lock
);
  assign mg_lo   = old_lo | (new_data[WORD_W-1:0] & mask_lo);
  assign mg_hi   = old_hi | (new_data[DATA_W-1:WORD_W] & mask_hi);
  assign mg_lock = old_lock | new_lock;
endmodule

// File: rtl/fps_timer.sv
// Down counter; expired while the count is zero.
module fps_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
  import fps_pkg::*;
#(
  parameter int NUM_LINES  = 64,
  parameter int LINE_W     = 8,
  parameter int CYC_PER_MS = 50000,
  parameter int SHORT_MS   = 1,
  parameter int LONG_MS    = 5,
  parameter int ADDR_W     = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [LINE_W-1:0] req_line,
  input  logic [63:0]       req_data,
  input  logic [31:0]       req_mask_lo,
  input  logic [31:0]       req_mask_hi,
  input  logic              req_lock,
  output logic              done,
  output logic [1:0]        status,
  output logic [31:0]       rd_lo,
  output logic [31:0]       rd_hi,
  output logic              rd_lock,
  output logic              prog_en,
  output logic [ADDR_W-1:0] fa_addr,
  output logic              fa_rd,
  input  logic [64:0]       fa_rdata,
  output logic              fa_wr,
  output logic [1:0]        fa_wsel,
  output logic [31:0]       fa_wdata
);
  localparam int SHORT_CYC = SHORT_MS * CYC_PER_MS;
  localparam int LONG_CYC  = LONG_MS * CYC_PER_MS;
  localparam int CNT_W     = $clog2(LONG_CYC + 1);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 2);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC - 2);

  typedef enum logic [2:0] {
    S_IDLE, S_DECIDE, S_RD_WAIT, S_RD_CAP, S_WRITE, S_WAIT, S_FIN
  } state_e;

  state_e              state;
  fps_status_e         status_q;
  logic                wr_q, lock_q;
  logic [LINE_W-1:0]   line_q;
  logic [DATA_W-1:0]   data_q;
  logic [WORD_W-1:0]   mlo_q, mhi_q;
  logic [WORD_W-1:0]   mg_lo_q, mg_hi_q;
  logic                mg_lock_q;
  logic [1:0]          wr_idx;

  logic                chk_reject, chk_skip;
  fps_status_e         chk_code;
  logic [WORD_W-1:0]   mg_lo, mg_hi;
  logic                mg_lock;
  logic                tmr_load, tmr_expired;
  logic [CNT_W-1:0]    tmr_val;

  fps_check #(.LINE_W(LINE_W), .NUM_LINES(NUM_LINES)) u_check (
    .is_write (wr_q),
    .line     (line_q),
    .data     (data_q),
    .mask_lo  (mlo_q),
    .mask_hi  (mhi_q),
    .lock     (lock_q),
    .reject   (chk_reject),
    .code     (chk_code),
    .skip     (chk_skip)
  );

  fps_merge u_merge (
    .old_lo   (fa_rdata[31:0]),
    .old_hi   (fa_rdata[63:32]),
    .old_lock (fa_rdata[64]),
    .new_data (data_q),
    .mask_lo  (mlo_q),
    .mask_hi  (mhi_q),
    .new_lock (lock_q),
    .mg_lo    (mg_lo),
    .mg_hi    (mg_hi),
    .mg_lock  (mg_lock)
  );

  assign tmr_load = (state == S_WRITE);
  assign tmr_val  = (wr_idx == 2'(WSEL_LOCK)) ? LONG_LD : SHORT_LD;

  fps_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  assign req_ready = (state == S_IDLE);
  assign status    = status_q;
  assign fa_addr   = line_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      status_q  <= ST_OK;
      done      <= 1'b0;
      prog_en   <= 1'b0;
      fa_rd     <= 1'b0;
      fa_wr     <= 1'b0;
      fa_wsel   <= 2'd0;
      fa_wdata  <= '0;
      rd_lo     <= '0;
      rd_hi     <= '0;
      rd_lock   <= 1'b0;
      wr_q      <= 1'b0;
      lock_q    <= 1'b0;
      line_q    <= '0;
      data_q    <= '0;
      mlo_q     <= '0;
      mhi_q     <= '0;
      mg_lo_q   <= '0;
      mg_hi_q   <= '0;
      mg_lock_q <= 1'b0;
      wr_idx    <= 2'd0;
    end else begin
      done  <= 1'b0;
      fa_rd <= 1'b0;
      fa_wr <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            wr_q   <= req_write;
            line_q <= req_line;
            data_q <= req_data;
            mlo_q  <= req_mask_lo;
            mhi_q  <= req_mask_hi;
            lock_q <= req_lock;
            state  <= S_DECIDE;
          end
        end
        S_DECIDE: begin
          status_q <= ST_OK;
          if (chk_reject) begin
            status_q <= chk_code;
            state    <= S_FIN;
          end else if (!wr_q) begin
            fa_rd <= 1'b1;
            state <= S_RD_WAIT;
          end else if (chk_skip) begin
            state <= S_FIN;
          end else begin
            prog_en <= 1'b1;
            fa_rd   <= 1'b1;
            state   <= S_RD_WAIT;
          end
        end
        S_RD_WAIT: state <= S_RD_CAP;
        S_RD_CAP: begin
          if (!wr_q) begin
            rd_lo   <= fa_rdata[31:0];
            rd_hi   <= fa_rdata[63:32];
            rd_lock <= fa_rdata[64];
            state   <= S_FIN;
          end else if (fa_rdata[64]) begin
            status_q <= ST_PERM;
            state    <= S_FIN;
          end else begin
            mg_lo_q   <= mg_lo;
            mg_hi_q   <= mg_hi;
            mg_lock_q <= mg_lock;
            wr_idx    <= 2'(WSEL_LO);
            state     <= S_WRITE;
          end
        end
        S_WRITE: begin
          fa_wr   <= 1'b1;
          fa_wsel <= wr_idx;
          case (wr_idx)
            2'(WSEL_LO): fa_wdata <= mg_lo_q;
            2'(WSEL_HI): fa_wdata <= mg_hi_q;
            default:     fa_wdata <= {{(WORD_W-1){1'b0}}, mg_lock_q};
          endcase
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (tmr_expired) begin
            if (wr_idx == 2'(WSEL_LOCK)) begin
              state <= S_FIN;
            end else begin
              wr_idx <= wr_idx + 2'd1;
              state  <= S_WRITE;
            end
          end
        end
        S_FIN: begin
          done    <= 1'b1;
          prog_en <= 1'b0;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fps_sva.sv
module fps_sva (
  input logic        clk,
  input logic        rst,
  input logic        req_ready,
  input logic        done,
  input logic        prog_en,
  input logic        fa_rd,
  input logic        fa_wr,
  input logic [1:0]  fa_wsel,
  input logic [31:0] fa_wdata
);
  p_wr_under_pen_r6: assert property (@(posedge clk) disable iff (rst)
    fa_wr |-> prog_en);
  p_done_pen_low_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !prog_en);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!prog_en && !fa_wr && !fa_rd));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_lock_word_one_r7: assert property (@(posedge clk) disable iff (rst)
    (fa_wr && fa_wsel == 2'd2) |-> (fa_wdata == 32'd1));
  p_wsel_legal_r5: assert property (@(posedge clk) disable iff (rst)
    fa_wr |-> (fa_wsel != 2'd3));
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(fa_rd && fa_wr));
  p_rd_single_r2: assert property (@(posedge clk) disable iff (rst)
    fa_rd |=> !fa_rd);
endmodule

bind fuse_prog_seq fps_sva u_sva (
  .clk      (clk),
  .rst      (rst),
  .req_ready(req_ready),
  .done     (done),
  .prog_en  (prog_en),
  .fa_rd    (fa_rd),
  .fa_wr    (fa_wr),
  .fa_wsel  (fa_wsel),
  .fa_wdata (fa_wdata)
);

// File: tb/tb_fuse_prog_seq.sv
module tb_fuse_prog_seq;
  localparam int MS = 4;
  localparam int NL = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_lock = 1'b0;
  logic [7:0]  req_line = '0;
  logic [63:0] req_data = '0;
  logic [31:0] req_mask_lo = '0, req_mask_hi = '0;
  logic        req_ready, done, rd_lock, prog_en, fa_rd, fa_wr;
  logic [1:0]  status, fa_wsel;
  logic [31:0] rd_lo, rd_hi, fa_wdata;
  logic [5:0]  fa_addr;
  logic [64:0] fa_rdata = '0;

  fuse_prog_seq #(.CYC_PER_MS(MS)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_line(req_line), .req_data(req_data),
    .req_mask_lo(req_mask_lo), .req_mask_hi(req_mask_hi), .req_lock(req_lock),
    .done(done), .status(status), .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_lock(rd_lock),
    .prog_en(prog_en), .fa_addr(fa_addr), .fa_rd(fa_rd), .fa_rdata(fa_rdata),
    .fa_wr(fa_wr), .fa_wsel(fa_wsel), .fa_wdata(fa_wdata)
  );

  function automatic logic [64:0] preload(input int i);
    logic [31:0] a, b;
    a = 32'(i) * 32'h9E37_79B1;
    b = 32'(i) * 32'h85EB_CA6B;
    return {(i >= 60), b, a};
  endfunction

  // behavioural fuse array, one-cycle read latency
  logic [64:0] mem [NL];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NL; i++) mem[i] <= preload(i);
    end else begin
      if (fa_rd) fa_rdata <= mem[fa_addr];
      if (fa_wr) begin
        case (fa_wsel)
          2'd0:    mem[fa_addr][31:0]  <= fa_wdata;
          2'd1:    mem[fa_addr][63:32] <= fa_wdata;
          default: mem[fa_addr][64]    <= fa_wdata[0];
        endcase
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // strobe monitor
  logic [7:0] wr_n = '0;
  int         wr_cyc [256];
  logic [1:0] wr_sel [256];
  int         pen_cnt = 0, prd_n = 0;
  always @(posedge clk) begin
    if (!rst) begin
      if (fa_wr) begin
        wr_cyc[wr_n] <= cyc;
        wr_sel[wr_n] <= fa_wsel;
        wr_n <= wr_n + 8'd1;
      end
      if (prog_en) pen_cnt <= pen_cnt + 1;
      if (fa_rd && prog_en) prd_n <= prd_n + 1;
    end
  end

  logic [64:0] ref_m [NL];
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [64:0] act,
                     input logic [64:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_status(input bit wr, input logic [7:0] line,
      input logic [63:0] d, input logic [31:0] m0, input logic [31:0] m1,
      input bit lk, output bit skip);
    skip = 0;
    if (line >= 8'(NL)) return 2'd2;
    if (!wr) return 2'd0;
    if (!lk || (|d[63:57])) return 2'd3;
    if (d == 64'd0 && ((|m0) || (|m1))) begin skip = 1; return 2'd0; end
    if (ref_m[line[5:0]][64]) return 2'd1;
    return 2'd0;
  endfunction

  task automatic run_op(input bit wr, input logic [7:0] line, input logic [63:0] d,
                        input logic [31:0] m0, input logic [31:0] m1, input bit lk);
    bit skip, prog;
    logic [1:0] es;
    logic [7:0] base_w;
    int base_pen, base_prd, t, done_cyc;
    logic [64:0] old, nw;
    es = exp_status(wr, line, d, m0, m1, lk, skip);
    prog = wr && es == 2'd0 && !skip;
    old = (line < 8'(NL)) ? ref_m[line[5:0]] : 65'd0;
    nw = {old[64] | lk, old[63:32] | (d[63:32] & m1), old[31:0] | (d[31:0] & m0)};
    while (!req_ready) @(negedge clk);
    base_w = wr_n; base_pen = pen_cnt; base_prd = prd_n;
    req_valid = 1; req_write = wr; req_line = line; req_data = d;
    req_mask_lo = m0; req_mask_hi = m1; req_lock = lk;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10 ready low while busy", 65'(req_ready), 65'd0);
    t = 0;
    while (!done && t < 1000) begin @(negedge clk); t++; end
    done_cyc = cyc;
    chk(done, "R10 done pulse", 65'(done), 65'd1);
    case (es)
      2'd2:    chk(status == es, "R1 NODEV status", 65'(status), 65'(es));
      2'd3:    chk(status == es, "R7 R8 INVAL status", 65'(status), 65'(es));
      2'd1:    chk(status == es, "R3 PERM status", 65'(status), 65'(es));
      default: chk(status == es, skip ? "R9 skip status" : "R10 OK status",
                   65'(status), 65'(es));
    endcase
    chk(!prog_en, "R6 prog_en low at done", 65'(prog_en), 65'd0);
    if (prog) begin
      chk(8'(wr_n - base_w) == 8'd3, "R5 strobe count", 65'(8'(wr_n - base_w)), 65'd3);
      chk(wr_sel[base_w] == 2'd0 && wr_sel[8'(base_w+1)] == 2'd1 &&
          wr_sel[8'(base_w+2)] == 2'd2, "R5 word order",
          65'({wr_sel[base_w], wr_sel[8'(base_w+1)], wr_sel[8'(base_w+2)]}), 65'h06);
      chk(wr_cyc[8'(base_w+1)] - wr_cyc[base_w] == MS, "R5 low-high gap",
          65'(wr_cyc[8'(base_w+1)] - wr_cyc[base_w]), 65'(MS));
      chk(wr_cyc[8'(base_w+2)] - wr_cyc[8'(base_w+1)] == MS, "R5 high-lock gap",
          65'(wr_cyc[8'(base_w+2)] - wr_cyc[8'(base_w+1)]), 65'(MS));
      chk(done_cyc - wr_cyc[8'(base_w+2)] == 5*MS, "R5 lock-done gap",
          65'(done_cyc - wr_cyc[8'(base_w+2)]), 65'(5*MS));
      chk(prd_n - base_prd == 1, "R6 read under prog_en", 65'(prd_n - base_prd), 65'd1);
      chk(mem[line[5:0]] == nw, "R4 merged line", mem[line[5:0]], nw);
      ref_m[line[5:0]] = nw;
    end else begin
      chk(wr_n == base_w, "R1 R3 R7 R8 R9 no write strobe", 65'(8'(wr_n - base_w)), 65'd0);
      if (line < 8'(NL))
        chk(mem[line[5:0]] == ref_m[line[5:0]], "R3 R7 R8 R9 line unchanged",
            mem[line[5:0]], ref_m[line[5:0]]);
      if (es == 2'd1)
        chk(pen_cnt != base_pen, "R6 enable on error path", 65'(pen_cnt - base_pen), 65'd1);
      else
        chk(pen_cnt == base_pen, "R2 R9 prog_en idle", 65'(pen_cnt - base_pen), 65'd0);
      if (!wr && es == 2'd0)
        chk({rd_lock, rd_hi, rd_lo} == ref_m[line[5:0]], "R2 read data",
            {rd_lock, rd_hi, rd_lo}, ref_m[line[5:0]]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL R10 watchdog expired actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NL; i++) ref_m[i] = preload(i);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready && !done && !prog_en && !fa_wr, "R10 reset state",
        65'({req_ready, done, prog_en, fa_wr}), 65'b1000);

    run_op(1, 8'd64, 64'd1, '1, '1, 1);                    // R1 edge
    run_op(1, 8'd200, 64'hFE00_0000_0000_0000, '1, '1, 0); // R1 wins over INVAL
    run_op(0, 8'd70, 64'd0, '0, '0, 0);                    // R1 read
    run_op(1, 8'd3, 64'h55, '1, '1, 0);                    // R7
    run_op(1, 8'd3, 64'h0200_0000_0000_0000, '1, '1, 1);   // R8 bit 57
    run_op(1, 8'd3, 64'hFE00_0000_0000_0001, '1, '1, 0);   // R7 and R8 together
    run_op(1, 8'd4, 64'd0, 32'hFFFF, 32'd0, 1);            // R9
    run_op(1, 8'd62, 64'd0, 32'd0, 32'h1, 1);              // R9 ahead of PERM
    run_op(1, 8'd5, 64'h0123_4567_89AB_CDEF, 32'hFFFF_0000, 32'h00FF_00FF, 1); // R4 R5
    run_op(1, 8'd5, 64'h1, '1, '1, 1);                     // R3
    run_op(0, 8'd5, 64'd0, '0, '0, 0);                     // R2
    run_op(1, 8'd6, 64'd0, 32'd0, 32'd0, 1);               // lock only
    run_op(1, 8'd7, 64'h0100_0000_0000_0000, '1, '1, 1);   // R8 bit 56 allowed
    run_op(1, 8'd61, 64'h10, '1, '1, 1);                   // R3 preloaded lock
    run_op(0, 8'd63, 64'd0, '0, '0, 0);                    // R2 last line

    for (int k = 0; k < 250; k++) begin
      logic [7:0]  ln;
      logic [63:0] d;
      bit w, lk;
      ln = ($urandom % 10 == 0) ? 8'(64 + $urandom % 192) : 8'($urandom % NL);
      d  = {$urandom, $urandom};
      if ($urandom % 4 != 0) d[63:57] = '0;
      if ($urandom % 10 == 0) d = '0;
      w  = ($urandom % 10) >= 3;
      lk = ($urandom % 8) != 0;
      run_op(w, ln, d, $urandom, $urandom, lk);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule